// File: doc/BRIEF.md
# Sensor Configuration Word Serializer

This block turns a set of imaging settings into one 51-bit control word. It then shifts the word out on a serial data line, one bit per master clock, while a separate enable line frames the transfer. The settings are the output mode, a three-bit gain code, horizontal and vertical flip, a two-bit window-size select and the corners of a user window. Software-side logic presents the fields on the `cfg_*` inputs and pulses `cfg_write`. The block checks the user window, queues the word and sends it when the line is free.

A sensor reads the word but acts on it only at the falling edge of the next frame reset strobe. The block therefore keeps a copy of the active settings, decoded into readable values: output mode, feedback capacitance in picofarads, flip bits, and image width and height. That copy changes only on such a falling edge, and only after a whole word has gone out. A repeat input re-sends the last word at every frame reset, for sensors that expect the word on each frame.

Top module: `sercfg_tx`

## Requirements
- R1: After reset, `ser_en`, `ser_dat` and `cfg_err` are 0. The active settings are single output, 14 pF, no flip, 640 columns and 480 rows.
- R2: An accepted write while idle raises `ser_en` in the second cycle after the write cycle. `ser_en` then stays high for 53 cycles: one setup cycle, 51 data cycles and one trailing cycle, with `ser_dat` at 0 in the setup and trailing cycles.
- R3: The data cycles carry the word most significant bit first, in this order: a 1 (start flag), four 0 bits, output-mode bit, gain[2:0], horizontal flip, vertical flip, size-select bits A then B, first row (9 bits), last row (9), first column (10), last column (10).
- R4: `ser_dat` is 0 in every cycle in which `ser_en` is low.
- R5: A write that arrives during a transfer does not disturb that transfer. The word is sent after it, with exactly one low cycle of `ser_en` between the two. If several writes arrive, only the last one is sent.
- R6: With size select 00 (user window), a write is rejected unless 160 ≤ first column ≤ last column ≤ 640 and 1 ≤ first row ≤ last row ≤ 480. A rejected write starts no transfer and sets `cfg_err`, which stays set until the next accepted write clears it. With any other size select the coordinates are not checked.
- R7: The active settings change only in the cycle after a falling edge of `frame_rst` is sampled. They change only if a complete word has been sent since the last update. Otherwise they keep their values.
- R8: The active capacitance follows the gain code: 111→18, 011→16, 101→14, 001→12, 110→10, 010→8, 100→6, 000→4 pF.
- R9: Size select 11, 10 and 01 give 640×480, 384×288 and 320×240. Size select 00 gives (last column − first column + 1) × (last row − first row + 1).
- R10: When `cfg_repeat` is high and a word has been sent before, each sampled falling edge of `frame_rst` queues the last sent word again, unless a word is already pending.
- R11: A write in the same cycle as a repeat trigger wins. Only the newly written word is sent.
- R12: The active output-mode flag `act_single` equals the output-mode bit of the applied word, where 1 means single output and 0 means double output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write | input | 1 | One-cycle strobe that submits the fields below |
| cfg_single | input | 1 | Output mode: 1 single, 0 double |
| cfg_gain | input | 3 | Gain code |
| cfg_hflip | input | 1 | Horizontal flip |
| cfg_vflip | input | 1 | Vertical flip |
| cfg_win | input | 2 | Size select {A,B} |
| cfg_row_first | input | 9 | User window first row |
| cfg_row_last | input | 9 | User window last row |
| cfg_col_first | input | 10 | User window first column |
| cfg_col_last | input | 10 | User window last column |
| cfg_repeat | input | 1 | Re-send the last word at each frame reset |
| frame_rst | input | 1 | Frame reset strobe from row timing |
| ser_en | output | 1 | Serial enable line framing a transfer |
| ser_dat | output | 1 | Serial data line |
| cfg_err | output | 1 | Last write was rejected |
| act_single | output | 1 | Applied output mode |
| act_cap_pf | output | 5 | Applied capacitance in pF |
| act_hflip | output | 1 | Applied horizontal flip |
| act_vflip | output | 1 | Applied vertical flip |
| act_cols | output | 10 | Applied image width |
| act_rows | output | 9 | Applied image height |

## Verification
A frame reset falling edge with `cfg_repeat` high queues a re-send. A new write queues a fresh word. Both can land in the same clock edge. The bench releases `frame_rst` in the same cycle that it raises `cfg_write`. It judges the result by capturing the next transfer bit by bit, which must be the new word, and by watching `ser_en` stay low long afterwards, so no second re-send follows. The same frame edge also applies the word finished just before, and the bench checks that the decoded active settings match it.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int ROW_W   = 9;
    localparam int COL_W   = 10;
    localparam int GAIN_W  = 3;
    localparam int CAP_W   = 5;
    localparam int HDR_W   = 5;
    localparam int COL_MIN = 160;
    localparam int COL_MAX = 640;
    localparam int ROW_MIN = 1;
    localparam int ROW_MAX = 480;

    typedef enum logic [1:0] {
        WIN_USER  = 2'b00,
        WIN_SMALL = 2'b01,
        WIN_MID   = 2'b10,
        WIN_FULL  = 2'b11
    } win_e;

    // field order equals transmission order after the header
    typedef struct packed {
        logic             single;
        logic [GAIN_W-1:0] gain;
        logic             hflip;
        logic             vflip;
        win_e             win;
        logic [ROW_W-1:0] row_first;
        logic [ROW_W-1:0] row_last;
        logic [COL_W-1:0] col_first;
        logic [COL_W-1:0] col_last;
    } cfg_t;

    localparam int WORD_W = HDR_W + $bits(cfg_t);
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_DATA, ST_HOLD} tx_st_e;

    function automatic word_t pack_word(cfg_t c);
        return {1'b1, {(HDR_W-1){1'b0}}, c};
    endfunction

    function automatic logic win_ok(cfg_t c);
        if (c.win != WIN_USER) return 1'b1;
        return (c.col_first >= COL_W'(COL_MIN)) && (c.col_last <= COL_W'(COL_MAX))
            && (c.col_first <= c.col_last)
            && (c.row_first >= ROW_W'(ROW_MIN)) && (c.row_last <= ROW_W'(ROW_MAX))
            && (c.row_first <= c.row_last);
    endfunction

    function automatic logic [CAP_W-1:0] gain_cap(logic [GAIN_W-1:0] g);
        case (g)
            3'b111:  return CAP_W'(18);
            3'b011:  return CAP_W'(16);
            3'b101:  return CAP_W'(14);
            3'b001:  return CAP_W'(12);
            3'b110:  return CAP_W'(10);
            3'b010:  return CAP_W'(8);
            3'b100:  return CAP_W'(6);
            default: return CAP_W'(4);
        endcase
    endfunction

    function automatic logic [COL_W-1:0] win_cols(cfg_t c);
        case (c.win)
            WIN_FULL:  return COL_W'(640);
            WIN_MID:   return COL_W'(384);
            WIN_SMALL: return COL_W'(320);
            default:   return c.col_last - c.col_first + COL_W'(1);
        endcase
    endfunction

    function automatic logic [ROW_W-1:0] win_rows(cfg_t c);
        case (c.win)
            WIN_FULL:  return ROW_W'(480);
            WIN_MID:   return ROW_W'(288);
            WIN_SMALL: return ROW_W'(240);
            default:   return c.row_last - c.row_first + ROW_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/sercfg_shift.sv
module sercfg_shift
    import sercfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t word,
    output logic  ser_en,
    output logic  ser_dat,
    output logic  busy,
    output logic  done
);
    localparam int CNT_W = $clog2(WORD_W);

    tx_st_e            state;
    word_t             sh;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sh    <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    sh    <= word;
                    state <= ST_SETUP;
                end
                ST_SETUP: begin
                    cnt   <= '0;
                    state <= ST_DATA;
                end
                ST_DATA: begin
                    sh  <= sh << 1;
                    cnt <= cnt + CNT_W'(1);
                    if (cnt == CNT_W'(WORD_W-1)) state <= ST_HOLD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ser_en  = (state != ST_IDLE);
    assign ser_dat = (state == ST_DATA) && sh[WORD_W-1];
    assign busy    = ser_en;
    assign done    = (state == ST_HOLD);

endmodule

// File: rtl/sercfg_apply.sv
module sercfg_apply
    import sercfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  cfg_t             sent_cfg,
    input  logic             frame_fall,
    output logic             act_single,
    output logic [CAP_W-1:0] act_cap_pf,
    output logic             act_hflip,
    output logic             act_vflip,
    output logic [COL_W-1:0] act_cols,
    output logic [ROW_W-1:0] act_rows
);
    cfg_t held;
    logic fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= '0;
            fresh      <= 1'b0;
            act_single <= 1'b1;
            act_cap_pf <= CAP_W'(14);
            act_hflip  <= 1'b0;
            act_vflip  <= 1'b0;
            act_cols   <= COL_W'(640);
            act_rows   <= ROW_W'(480);
        end else begin
            if (frame_fall && fresh) begin
                act_single <= held.single;
                act_cap_pf <= gain_cap(held.gain);
                act_hflip  <= held.hflip;
                act_vflip  <= held.vflip;
                act_cols   <= win_cols(held);
                act_rows   <= win_rows(held);
                fresh      <= 1'b0;
            end
            if (done) begin
                held  <= sent_cfg;
                fresh <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sercfg_tx.sv
module sercfg_tx
    import sercfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_write,
    input  logic             cfg_single,
    input  logic [2:0]       cfg_gain,
    input  logic             cfg_hflip,
    input  logic             cfg_vflip,
    input  logic [1:0]       cfg_win,
    input  logic [8:0]       cfg_row_first,
    input  logic [8:0]       cfg_row_last,
    input  logic [9:0]       cfg_col_first,
    input  logic [9:0]       cfg_col_last,
    input  logic             cfg_repeat,
    input  logic             frame_rst,
    output logic             ser_en,
    output logic             ser_dat,
    output logic             cfg_err,
    output logic             act_single,
    output logic [4:0]       act_cap_pf,
    output logic             act_hflip,
    output logic             act_vflip,
    output logic [9:0]       act_cols,
    output logic [8:0]       act_rows
);
    cfg_t  cfg_in, pend_cfg, tx_cfg;
    logic  frame_q, frame_fall;
    logic  pend, has_sent, wr_ok, start, busy, done;
    word_t tx_word;

    always_comb begin
        cfg_in.single    = cfg_single;
        cfg_in.gain      = cfg_gain;
        cfg_in.hflip     = cfg_hflip;
        cfg_in.vflip     = cfg_vflip;
        cfg_in.win       = win_e'(cfg_win);
        cfg_in.row_first = cfg_row_first;
        cfg_in.row_last  = cfg_row_last;
        cfg_in.col_first = cfg_col_first;
        cfg_in.col_last  = cfg_col_last;
    end

    assign frame_fall = frame_q && !frame_rst;
    assign wr_ok      = cfg_write && win_ok(cfg_in);
    assign start      = pend && !busy;
    assign tx_word    = pack_word(pend_cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q  <= 1'b0;
            pend     <= 1'b0;
            has_sent <= 1'b0;
            cfg_err  <= 1'b0;
            pend_cfg <= '0;
            tx_cfg   <= '0;
        end else begin
            frame_q <= frame_rst;
            if (start) begin
                pend     <= 1'b0;
                tx_cfg   <= pend_cfg;
                has_sent <= 1'b1;
            end
            // a write of either outcome takes priority over a repeat trigger
            if (wr_ok) begin
                pend     <= 1'b1;
                pend_cfg <= cfg_in;
                cfg_err  <= 1'b0;
            end else if (cfg_write) begin
                cfg_err  <= 1'b1;
            end else if (frame_fall && cfg_repeat && has_sent && !pend) begin
                pend     <= 1'b1;
                pend_cfg <= tx_cfg;
            end
        end
    end

    sercfg_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .word    (tx_word),
        .ser_en  (ser_en),
        .ser_dat (ser_dat),
        .busy    (busy),
        .done    (done)
    );

    sercfg_apply u_apply (
        .clk        (clk),
        .rst        (rst),
        .done       (done),
        .sent_cfg   (tx_cfg),
        .frame_fall (frame_fall),
        .act_single (act_single),
        .act_cap_pf (act_cap_pf),
        .act_hflip  (act_hflip),
        .act_vflip  (act_vflip),
        .act_cols   (act_cols),
        .act_rows   (act_rows)
    );

endmodule

// File: rtl/sercfg_tx_chk.sv
module sercfg_tx_chk
    import sercfg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ser_en,
    input logic       ser_dat,
    input logic       cfg_write,
    input logic       cfg_err,
    input logic       frame_rst,
    input logic       act_single,
    input logic [4:0] act_cap_pf,
    input logic [9:0] act_cols,
    input logic [8:0] act_rows
);
    localparam int RUN_LEN = WORD_W + 2;
    localparam int CW      = $clog2(RUN_LEN + 1);

    logic [CW-1:0] en_run;

    always_ff @(posedge clk) begin
        if (rst)         en_run <= '0;
        else if (ser_en) en_run <= en_run + CW'(1);
        else             en_run <= '0;
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !ser_en |-> !ser_dat);                                          // R4
    AST_START_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_en) |=> ser_dat);                                     // R3
    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_en) |-> en_run == CW'(RUN_LEN));                      // R2
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$fell(frame_rst) |=> $stable(act_cap_pf) && $stable(act_cols)
                              && $stable(act_rows) && $stable(act_single)); // R7
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_write |=> $stable(cfg_err));                               // R6
    AST_CAP_RANGE: assert property (@(posedge clk) disable iff (rst)
        act_cap_pf >= 5'd4 && act_cap_pf <= 5'd18 && !act_cap_pf[0]);   // R8

endmodule

bind sercfg_tx sercfg_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_en     (ser_en),
    .ser_dat    (ser_dat),
    .cfg_write  (cfg_write),
    .cfg_err    (cfg_err),
    .frame_rst  (frame_rst),
    .act_single (act_single),
    .act_cap_pf (act_cap_pf),
    .act_cols   (act_cols),
    .act_rows   (act_rows)
);

// File: tb/sercfg_tx_tb.sv
module sercfg_tx_tb;

    typedef struct packed {
        logic       single;
        logic [2:0] gain;
        logic       hf;
        logic       vf;
        logic [1:0] win;
        logic [8:0] rf;
        logic [8:0] rl;
        logic [9:0] cf;
        logic [9:0] cl;
        logic       ok;
        logic [4:0] cap;
        logic [9:0] cols;
        logic [8:0] rows;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0,3'b111,1'b1,1'b1,2'b11,9'd0,  9'd0,  10'd0,  10'd0,  1'b1,5'd18,10'd640,9'd480},
        '{1'b1,3'b011,1'b0,1'b1,2'b10,9'd0,  9'd0,  10'd0,  10'd0,  1'b1,5'd16,10'd384,9'd288},
        '{1'b0,3'b101,1'b1,1'b0,2'b01,9'd0,  9'd0,  10'd0,  10'd0,  1'b1,5'd14,10'd320,9'd240},
        '{1'b1,3'b001,1'b0,1'b0,2'b00,9'd100,9'd299,10'd160,10'd479,1'b1,5'd12,10'd320,9'd200},
        '{1'b0,3'b110,1'b0,1'b0,2'b00,9'd1,  9'd480,10'd200,10'd100,1'b0,5'd0, 10'd0,  9'd0  },
        '{1'b0,3'b110,1'b1,1'b0,2'b00,9'd1,  9'd480,10'd160,10'd640,1'b1,5'd10,10'd481,9'd480},
        '{1'b1,3'b011,1'b0,1'b0,2'b00,9'd10, 9'd20, 10'd159,10'd300,1'b0,5'd0, 10'd0,  9'd0  },
        '{1'b1,3'b011,1'b0,1'b0,2'b00,9'd0,  9'd20, 10'd160,10'd300,1'b0,5'd0, 10'd0,  9'd0  },
        '{1'b1,3'b010,1'b1,1'b1,2'b11,9'd400,9'd3,  10'd7,  10'd2,  1'b1,5'd8, 10'd640,9'd480},
        '{1'b1,3'b011,1'b0,1'b0,2'b00,9'd300,9'd200,10'd160,10'd300,1'b0,5'd0, 10'd0,  9'd0  },
        '{1'b0,3'b000,1'b0,1'b1,2'b00,9'd5,  9'd5,  10'd200,10'd200,1'b1,5'd4, 10'd1,  9'd1  },
        '{1'b0,3'b010,1'b0,1'b0,2'b00,9'd1,  9'd481,10'd160,10'd641,1'b0,5'd0, 10'd0,  9'd0  },
        '{1'b0,3'b100,1'b0,1'b1,2'b10,9'd0,  9'd0,  10'd0,  10'd0,  1'b1,5'd6, 10'd384,9'd288}
    };

    localparam vec_t RST_V = '{1'b1,3'b101,1'b0,1'b0,2'b11,9'd0,9'd0,10'd0,10'd0,1'b1,5'd14,10'd640,9'd480};

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_write = 0, cfg_single = 0, cfg_hflip = 0, cfg_vflip = 0, cfg_repeat = 0, frame_rst = 0;
    logic [2:0] cfg_gain = 0;
    logic [1:0] cfg_win = 0;
    logic [8:0] cfg_row_first = 0, cfg_row_last = 0;
    logic [9:0] cfg_col_first = 0, cfg_col_last = 0;
    logic ser_en, ser_dat, cfg_err, act_single, act_hflip, act_vflip;
    logic [4:0] act_cap_pf;
    logic [9:0] act_cols;
    logic [8:0] act_rows;

    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    sercfg_tx u_dut (.*);

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic logic [50:0] exp_word(vec_t v);
        return {1'b1, 4'b0000, v.single, v.gain, v.hf, v.vf, v.win, v.rf, v.rl, v.cf, v.cl};
    endfunction

    task automatic write_cfg(vec_t v);
        cfg_single = v.single; cfg_gain = v.gain; cfg_hflip = v.hf; cfg_vflip = v.vf;
        cfg_win = v.win; cfg_row_first = v.rf; cfg_row_last = v.rl;
        cfg_col_first = v.cf; cfg_col_last = v.cl;
        cfg_write = 1'b1;
        @(negedge clk);
        cfg_write = 1'b0;
    endtask

    task automatic frame_pulse();
        frame_rst = 1'b1;
        @(negedge clk);
        frame_rst = 1'b0;
        @(negedge clk);
    endtask

    // waits for a transfer, captures it and checks its framing
    task automatic recv(output logic [50:0] w, output int gap);
        bit idle_ok = 1;
        gap = 0;
        w = '0;
        @(negedge clk);
        while (!ser_en && gap < 300) begin
            if (ser_dat) idle_ok = 0;
            gap++;
            @(negedge clk);
        end
        chk("R4 data low while idle", idle_ok, 1);
        chk("R2 setup cycle", {ser_en, ser_dat}, 2'b10);
        for (int i = 50; i >= 0; i--) begin
            @(negedge clk);
            w[i] = ser_dat;
            if (!ser_en) chk("R2 enable during data", ser_en, 1);
        end
        @(negedge clk);
        chk("R2 trailing cycle", {ser_en, ser_dat}, 2'b10);
        @(negedge clk);
        chk("R2 enable drops", ser_en, 0);
    endtask

    task automatic chk_act(string req, vec_t v);
        chk({req, " single"}, act_single, v.single);
        chk({req, " cap"}, act_cap_pf, v.cap);
        chk({req, " flips"}, {act_hflip, act_vflip}, {v.hf, v.vf});
        chk({req, " cols"}, act_cols, v.cols);
        chk({req, " rows"}, act_rows, v.rows);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        vec_t cur;
        logic [50:0] w, w2;
        int gap, gap2;
        bit quiet;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 serial lines", {ser_en, ser_dat, cfg_err}, 3'b000);
        chk_act("R1", RST_V);
        cur = RST_V;

        // R3 R6 R7 R8 R9 R12: table walk
        for (int k = 0; k < NV; k++) begin
            write_cfg(VEC[k]);
            if (VEC[k].ok) begin
                recv(w, gap);
                chk("R2 start latency", gap, 0);
                chk("R3 word content", w, exp_word(VEC[k]));
                chk("R6 error cleared", cfg_err, 0);
                chk_act("R7 not yet applied", cur);
                frame_pulse();
                cur = VEC[k];
                chk_act("R8 R9 R12 applied", cur);
            end else begin
                quiet = 1;
                for (int j = 0; j < 60; j++) begin
                    @(negedge clk);
                    if (ser_en) quiet = 0;
                end
                chk("R6 rejected no transfer", quiet, 1);
                chk("R6 error set", cfg_err, 1);
                frame_pulse();
                chk_act("R6 R7 settings kept", cur);
            end
        end

        // R5: writes during a transfer are held off, last one wins
        write_cfg(VEC[0]);
        fork
            begin
                recv(w, gap);
                recv(w2, gap2);
            end
            begin
                repeat (10) @(negedge clk);
                write_cfg(VEC[1]);
                write_cfg(VEC[3]);
            end
        join
        chk("R5 first word intact", w, exp_word(VEC[0]));
        chk("R5 last pending word", w2, exp_word(VEC[3]));
        chk("R5 one low cycle between", gap2, 0);
        chk_act("R7 held before frame edge", cur);

        // R10: repeat re-sends the last word at a frame edge
        cfg_repeat = 1'b1;
        frame_pulse();
        cur = VEC[3];
        chk_act("R7 applied on frame edge", cur);
        recv(w, gap);
        chk("R10 repeated word", w, exp_word(VEC[3]));
        chk("R10 repeat latency", gap, 0);

        // R11: write in the same cycle as a repeat trigger
        frame_rst = 1'b1;
        @(negedge clk);
        frame_rst = 1'b0;
        write_cfg(VEC[12]);
        chk_act("R7 repeat word applied", cur);
        recv(w, gap);
        chk("R11 new word wins", w, exp_word(VEC[12]));
        quiet = 1;
        for (int j = 0; j < 80; j++) begin
            @(negedge clk);
            if (ser_en) quiet = 0;
        end
        chk("R11 no extra re-send", quiet, 1);
        cfg_repeat = 1'b0;
        frame_pulse();
        chk_act("R8 R9 R12 after race", VEC[12]);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule